// File: doc/BRIEF.md
# Auxiliary Region Access Controller for a Two-Wire EEPROM

This block sits between the byte-level engine of a two-wire serial EEPROM and two small regions that live beside the main array. The first region is a 128-byte writable security sector guarded by a one-time lock. The second is a 128-bit factory identifier that can only be read. The bus engine hands over byte events: a device-address byte, word-address bytes, data bytes to write, requests for a byte to read, and the end of a transfer. The block answers each event with an acknowledge decision or a read byte, one clock later.

A device-address byte whose upper nibble is 1011 opens an auxiliary session. The next two word-address bytes then pick the target. Bits 2:1 of the first word-address byte (address bits 10:9) select the sector, the lock flag or the identifier. The second byte supplies the byte index. The target and index persist across transfers, so a current-address read continues where the last access stopped. A 1010 nibble opens a main-array session. In that case the block only reports the region and leaves the rest of the traffic to other logic. The nonvolatile storage is modelled as registers that reset to the erased value 0xFF. The lock resets to clear.

Top module: `sec_aux_ctrl`

## Requirements
- R1: One cycle after `dev_stb`, `ack_vld`=1. `ack`=1 only if `dev_byte[3:1]` equals `chip_pins` and `dev_byte[7:4]` is 1010 (then `region`=1, main) or 1011 (auxiliary session opens). Any other byte gives `ack`=0 and `region`=0.
- R2: In an auxiliary session, a first word-address byte with bits 2:1 = 00 selects the sector (`region`=2). The second byte's bits 6:0 become `byte_idx`, and all other bits are ignored. Both word-address bytes are acknowledged.
- R3: A first word-address byte with bits 2:1 = 10 selects the lock flag (`region`=3). All other address bits are ignored.
- R4: A first word-address byte with bit 1 = 1 selects the identifier (`region`=4). `byte_idx` becomes bits 3:0 of the second byte.
- R5: While unlocked, each data byte written to the sector is acknowledged and stored at `byte_idx`. The index then increments and wraps from 127 to 0.
- R6: An acknowledged data byte written to the lock flag sets the lock if its bit 1 is 1 and leaves the lock unchanged otherwise. Once set, `locked` never clears.
- R7: While locked, data bytes written to the sector or the lock flag get `ack`=0. They change no stored byte and do not move the index.
- R8: Data bytes written to the identifier get `ack`=0. Identifier reads return byte k as bits [127-8k -: 8] of the identifier (most significant byte is index 0), and the index wraps from 15 to 0.
- R9: A read of the lock flag returns a byte with bit 1 equal to the lock state and all other bits 0, and does not move the index.
- R10: Sector reads return the stored byte at `byte_idx` one cycle after `rd_stb` with `rd_vld`=1. The index then increments and wraps from 127 to 0.
- R11: Outside an auxiliary session (after `end_stb`, a failed device match, or in a main session), `wa_stb`, `wr_stb` and `rd_stb` produce no `ack_vld`, no `rd_vld` and no state change.
- R12: After reset, `ack_vld`=0, `rd_vld`=0, `region`=0 and `locked`=0. `ack_vld` and `rd_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_pins | input | 3 | Strapped chip-select value compared with device-address bits 3:1 |
| dev_stb | input | 1 | Device-address byte present |
| dev_byte | input | 8 | Device-address byte (nibble, chip bits, R/W in bit 0) |
| wa_stb | input | 1 | Word-address byte present (high byte first) |
| wa_byte | input | 8 | Word-address byte |
| wr_stb | input | 1 | Data byte to write present |
| wr_byte | input | 8 | Data byte to write |
| rd_stb | input | 1 | Request for the next read byte |
| end_stb | input | 1 | Transfer ended (stop seen) |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_vld | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| region | output | 3 | 0 none, 1 main, 2 sector, 3 lock flag, 4 identifier |
| byte_idx | output | 7 | Current index within the selected region |
| locked | output | 1 | Sector lock state |

## Verification
The bench fills the last two sector bytes and lets the index run across the 127 to 0 boundary, both on writes and on reads. A design that stopped at the top of the sector or spilled into a wider counter would store or return the wrong byte at index 0. It sends a lock write with bit 1 clear, which must not lock, and then one with bit 1 set. After locking it checks that both sector and lock writes are refused and that the sector content and index stay where they were. A design with an inverted or lost lock would accept those bytes or overwrite index 0. Identifier reads cross index 15 and use an address whose bits 10:9 are 11, catching a decoder that demands 01 or reads the identifier bytes in the wrong order.

// File: rtl/aux_pkg.sv
package aux_pkg;

    localparam logic [3:0] CODE_MAIN = 4'b1010;
    localparam logic [3:0] CODE_AUX  = 4'b1011;
    localparam int         LOCK_POS  = 1;
    localparam logic [7:0] ERASED    = 8'hFF;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_MAIN = 3'd1,
        RG_SECT = 3'd2,
        RG_LOCK = 3'd3,
        RG_UID  = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_MAIN = 2'd1,
        SS_AUX  = 2'd2
    } sess_e;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] chip;
        logic       rd;
    } devword_t;

    typedef struct packed {
        logic       vld;
        logic       ok;
    } ackword_t;

    // sel = word-address bits 10:9
    function automatic region_e aux_target(input logic [1:0] sel);
        if (sel[0])
            return RG_UID;
        else if (sel[1])
            return RG_LOCK;
        else
            return RG_SECT;
    endfunction

    function automatic logic [7:0] lock_byte(input logic lk);
        logic [7:0] b;
        b = '0;
        b[LOCK_POS] = lk;
        return b;
    endfunction

endpackage

// File: rtl/aux_session.sv
module aux_session
    import aux_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int UIDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       chip_pins,
    input  logic             dev_stb,
    input  logic [7:0]       dev_byte,
    input  logic             wa_stb,
    input  logic [7:0]       wa_byte,
    input  logic             end_stb,
    input  logic             adv,
    output sess_e            sess,
    output region_e          tgt,
    output logic [IDX_W-1:0] ptr,
    output logic             dev_ack
);

    devword_t dw;
    logic     chip_ok, hit_main, hit_aux;
    logic     phase_q;
    logic [1:0] sel_q;
    region_e  new_tgt;
    logic [IDX_W-1:0] new_ptr;
    logic [IDX_W-1:0] nxt_ptr;

    assign dw       = devword_t'(dev_byte);
    assign chip_ok  = (dw.chip == chip_pins);
    assign hit_main = chip_ok && (dw.code == CODE_MAIN);
    assign hit_aux  = chip_ok && (dw.code == CODE_AUX);
    assign dev_ack  = hit_main || hit_aux;

    always_comb begin
        new_tgt = aux_target(sel_q);
        case (new_tgt)
            RG_UID:  new_ptr = IDX_W'(wa_byte[UIDX_W-1:0]);
            RG_LOCK: new_ptr = '0;
            default: new_ptr = wa_byte[IDX_W-1:0];
        endcase
    end

    always_comb begin
        if (tgt == RG_UID)
            nxt_ptr = IDX_W'(ptr[UIDX_W-1:0] + UIDX_W'(1));
        else
            nxt_ptr = ptr + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sess    <= SS_IDLE;
            tgt     <= RG_SECT;
            ptr     <= '0;
            phase_q <= 1'b0;
            sel_q   <= 2'b00;
        end else if (dev_stb) begin
            sess    <= hit_aux ? SS_AUX : (hit_main ? SS_MAIN : SS_IDLE);
            phase_q <= 1'b0;
        end else if (end_stb) begin
            sess    <= SS_IDLE;
            phase_q <= 1'b0;
        end else if (wa_stb && sess == SS_AUX) begin
            if (!phase_q) begin
                sel_q   <= wa_byte[2:1];
                phase_q <= 1'b1;
            end else begin
                tgt     <= new_tgt;
                ptr     <= new_ptr;
                phase_q <= 1'b0;
            end
        end else if (adv) begin
            ptr <= nxt_ptr;
        end
    end

endmodule

// File: rtl/aux_store.sv
module aux_store
    import aux_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic             lock_set,
    output logic [7:0]       rdata,
    output logic             locked
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ERASED;
        end else if (we && !locked) begin
            mem[idx] <= wdata;
        end
    end

    // one-time lock: no path back to zero except reset of the model
    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (lock_set)
            locked <= 1'b1;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/aux_read_mux.sv
module aux_read_mux
    import aux_pkg::*;
#(
    parameter int ID_BYTES = 16,
    parameter int IDX_W    = 7,
    parameter int UIDX_W   = $clog2(ID_BYTES)
) (
    input  region_e               tgt,
    input  logic [IDX_W-1:0]      ptr,
    input  logic [7:0]            sec_rdata,
    input  logic                  locked,
    input  logic [ID_BYTES*8-1:0] uid,
    output logic [7:0]            rbyte
);

    logic [7:0] uid_b;

    always_comb begin
        uid_b = '0;
        for (int k = 0; k < ID_BYTES; k++) begin
            if (ptr[UIDX_W-1:0] == UIDX_W'(k))
                uid_b = uid[(ID_BYTES-1-k)*8 +: 8];
        end
    end

    always_comb begin
        case (tgt)
            RG_SECT: rbyte = sec_rdata;
            RG_LOCK: rbyte = lock_byte(locked);
            RG_UID:  rbyte = uid_b;
            default: rbyte = ERASED;
        endcase
    end

endmodule

// File: rtl/sec_aux_ctrl.sv
module sec_aux_ctrl
    import aux_pkg::*;
#(
    parameter int SECT_BYTES = 128,
    parameter int ID_BYTES   = 16,
    parameter logic [ID_BYTES*8-1:0] UID_VALUE = 128'h5A3C_96E1_0F77_2B48_D10C_E95A_6633_81F4,
    localparam int IDX_W     = $clog2(SECT_BYTES),
    localparam int UIDX_W    = $clog2(ID_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       chip_pins,
    input  logic             dev_stb,
    input  logic [7:0]       dev_byte,
    input  logic             wa_stb,
    input  logic [7:0]       wa_byte,
    input  logic             wr_stb,
    input  logic [7:0]       wr_byte,
    input  logic             rd_stb,
    input  logic             end_stb,
    output logic             ack_vld,
    output logic             ack,
    output logic             rd_vld,
    output logic [7:0]       rd_data,
    output logic [2:0]       region,
    output logic [IDX_W-1:0] byte_idx,
    output logic             locked
);

    sess_e            sess;
    region_e          tgt;
    logic [IDX_W-1:0] ptr;
    logic             dev_ack;
    logic             aux_open;
    logic             wa_go, wr_go, rd_go;
    logic             wr_ok, sec_we, lock_set, adv;
    logic [7:0]       sec_rdata, rbyte;
    ackword_t         resp;

    assign aux_open = (sess == SS_AUX);
    // one event per cycle: device byte, then end, then address, write, read
    assign wa_go  = wa_stb && !dev_stb && !end_stb && aux_open;
    assign wr_go  = wr_stb && !dev_stb && !end_stb && !wa_stb && aux_open;
    assign rd_go  = rd_stb && !dev_stb && !end_stb && !wa_stb && !wr_stb && aux_open;

    assign wr_ok    = wr_go && !locked && (tgt == RG_SECT || tgt == RG_LOCK);
    assign sec_we   = wr_ok && (tgt == RG_SECT);
    assign lock_set = wr_ok && (tgt == RG_LOCK) && wr_byte[LOCK_POS];
    assign adv      = sec_we || (rd_go && tgt != RG_LOCK);

    aux_session #(
        .IDX_W  (IDX_W),
        .UIDX_W (UIDX_W)
    ) u_sess (
        .clk       (clk),
        .rst       (rst),
        .chip_pins (chip_pins),
        .dev_stb   (dev_stb),
        .dev_byte  (dev_byte),
        .wa_stb    (wa_stb),
        .wa_byte   (wa_byte),
        .end_stb   (end_stb),
        .adv       (adv),
        .sess      (sess),
        .tgt       (tgt),
        .ptr       (ptr),
        .dev_ack   (dev_ack)
    );

    aux_store #(
        .DEPTH (SECT_BYTES),
        .IDX_W (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (sec_we),
        .idx      (ptr),
        .wdata    (wr_byte),
        .lock_set (lock_set),
        .rdata    (sec_rdata),
        .locked   (locked)
    );

    aux_read_mux #(
        .ID_BYTES (ID_BYTES),
        .IDX_W    (IDX_W),
        .UIDX_W   (UIDX_W)
    ) u_rmux (
        .tgt       (tgt),
        .ptr       (ptr),
        .sec_rdata (sec_rdata),
        .locked    (locked),
        .uid       (UID_VALUE),
        .rbyte     (rbyte)
    );

    always_comb begin
        resp.vld = dev_stb || wa_go || wr_go;
        if (dev_stb)
            resp.ok = dev_ack;
        else if (wa_go)
            resp.ok = 1'b1;
        else
            resp.ok = wr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            ack_vld <= resp.vld;
            ack     <= resp.vld && resp.ok;
            rd_vld  <= rd_go;
            if (rd_go)
                rd_data <= rbyte;
        end
    end

    always_comb begin
        case (sess)
            SS_MAIN: region = RG_MAIN;
            SS_AUX:  region = tgt;
            default: region = RG_NONE;
        endcase
    end

    assign byte_idx = aux_open ? ptr : '0;

endmodule

// File: rtl/aux_ctrl_chk.sv
module aux_ctrl_chk
    import aux_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dev_stb,
    input logic       wa_stb,
    input logic       wr_stb,
    input logic       wr_lockbit,
    input logic       rd_stb,
    input logic       end_stb,
    input logic       ack_vld,
    input logic       ack,
    input logic       rd_vld,
    input logic [7:0] rd_data,
    input logic [2:0] region,
    input logic       locked
);

    logic wr_only, rd_only;
    assign wr_only = wr_stb && !dev_stb && !end_stb && !wa_stb;
    assign rd_only = rd_stb && !dev_stb && !end_stb && !wa_stb && !wr_stb;

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    p_lock_set_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_only && region == RG_LOCK && !locked && wr_lockbit) |=> locked);

    p_locked_nack_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_only && locked && (region == RG_SECT || region == RG_LOCK)) |=> (ack_vld && !ack));

    p_uid_nack_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_only && region == RG_UID) |=> (ack_vld && !ack));

    p_lock_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_only && region == RG_LOCK) |=> (rd_vld && rd_data == lock_byte(locked)));

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!dev_stb && (region == RG_NONE || region == RG_MAIN)) |=> (!ack_vld && !rd_vld));

    p_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(ack_vld && rd_vld));

endmodule

bind sec_aux_ctrl aux_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_stb    (dev_stb),
    .wa_stb     (wa_stb),
    .wr_stb     (wr_stb),
    .wr_lockbit (wr_byte[1]),
    .rd_stb     (rd_stb),
    .end_stb    (end_stb),
    .ack_vld    (ack_vld),
    .ack        (ack),
    .rd_vld     (rd_vld),
    .rd_data    (rd_data),
    .region     (region),
    .locked     (locked)
);

// File: tb/sim_sec_aux_ctrl.sv
module sim_sec_aux_ctrl;

    localparam logic [127:0] UID = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [2:0] OP_END = 3'd0, OP_DEV = 3'd1, OP_WA = 3'd2, OP_WR = 3'd3, OP_RD = 3'd4;
    localparam int NV = 60;

    // {requirement, op, input byte, expected ack (bit 0) or read byte}
    localparam logic [22:0] VEC [NV] = '{
        {4'd1,  OP_DEV, 8'hBA, 8'h01},   // R1 aux write open
        {4'd2,  OP_WA,  8'hF9, 8'h01},   // R2 bits 10:9 = 00, rest set
        {4'd2,  OP_WA,  8'hFE, 8'h01},   // R2 index 0x7E, bit 7 ignored
        {4'd5,  OP_WR,  8'h11, 8'h01},   // R5
        {4'd5,  OP_WR,  8'h22, 8'h01},   // R5 index 127
        {4'd5,  OP_WR,  8'h33, 8'h01},   // R5 wrapped to 0
        {4'd5,  OP_END, 8'h00, 8'h00},
        {4'd1,  OP_DEV, 8'hBA, 8'h01},
        {4'd2,  OP_WA,  8'h00, 8'h01},
        {4'd2,  OP_WA,  8'h7E, 8'h01},
        {4'd1,  OP_DEV, 8'hBB, 8'h01},
        {4'd10, OP_RD,  8'h00, 8'h11},   // R10
        {4'd10, OP_RD,  8'h00, 8'h22},
        {4'd10, OP_RD,  8'h00, 8'h33},   // R10 wrap
        {4'd10, OP_RD,  8'h00, 8'hFF},   // erased byte
        {4'd10, OP_END, 8'h00, 8'h00},
        {4'd3,  OP_DEV, 8'hBA, 8'h01},   // R3
        {4'd3,  OP_WA,  8'hFC, 8'h01},
        {4'd3,  OP_WA,  8'h5A, 8'h01},
        {4'd3,  OP_DEV, 8'hBB, 8'h01},
        {4'd9,  OP_RD,  8'h00, 8'h00},   // R9 unlocked
        {4'd9,  OP_END, 8'h00, 8'h00},
        {4'd6,  OP_DEV, 8'hBA, 8'h01},   // R6
        {4'd6,  OP_WA,  8'h04, 8'h01},
        {4'd6,  OP_WA,  8'h00, 8'h01},
        {4'd6,  OP_WR,  8'hFD, 8'h01},   // bit 1 clear: no lock
        {4'd6,  OP_END, 8'h00, 8'h00},
        {4'd6,  OP_DEV, 8'hBB, 8'h01},
        {4'd6,  OP_RD,  8'h00, 8'h00},   // R6 still unlocked
        {4'd6,  OP_END, 8'h00, 8'h00},
        {4'd8,  OP_DEV, 8'hBA, 8'h01},   // R8
        {4'd8,  OP_WA,  8'h02, 8'h01},
        {4'd8,  OP_WA,  8'hFE, 8'h01},
        {4'd8,  OP_WR,  8'h55, 8'h00},   // R8 identifier write refused
        {4'd8,  OP_DEV, 8'hBB, 8'h01},
        {4'd8,  OP_RD,  8'h00, 8'hEE},
        {4'd8,  OP_RD,  8'h00, 8'hFF},
        {4'd8,  OP_RD,  8'h00, 8'h00},   // R8 wrap 15 -> 0
        {4'd8,  OP_END, 8'h00, 8'h00},
        {4'd4,  OP_DEV, 8'hBA, 8'h01},   // R4 bits 10:9 = 11
        {4'd4,  OP_WA,  8'h06, 8'h01},
        {4'd4,  OP_WA,  8'h03, 8'h01},
        {4'd4,  OP_DEV, 8'hBB, 8'h01},
        {4'd4,  OP_RD,  8'h00, 8'h33},
        {4'd4,  OP_END, 8'h00, 8'h00},
        {4'd1,  OP_DEV, 8'hB0, 8'h00},   // R1 chip mismatch
        {4'd1,  OP_DEV, 8'hAA, 8'h01},   // R1 main array
        {4'd1,  OP_DEV, 8'h1A, 8'h00},   // R1 bad nibble
        {4'd6,  OP_DEV, 8'hBA, 8'h01},
        {4'd6,  OP_WA,  8'h04, 8'h01},
        {4'd6,  OP_WA,  8'h00, 8'h01},
        {4'd6,  OP_WR,  8'h02, 8'h01},   // R6 lock now set
        {4'd7,  OP_WR,  8'h00, 8'h00},   // R7 lock write refused
        {4'd7,  OP_END, 8'h00, 8'h00},
        {4'd7,  OP_DEV, 8'hBA, 8'h01},
        {4'd7,  OP_WA,  8'h00, 8'h01},
        {4'd7,  OP_WA,  8'h00, 8'h01},
        {4'd7,  OP_WR,  8'h99, 8'h00},   // R7 sector write refused
        {4'd7,  OP_DEV, 8'hBB, 8'h01},
        {4'd7,  OP_RD,  8'h00, 8'h33}    // R7 content and index kept
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] chip_pins = 3'b101;
    logic       dev_stb = 0, wa_stb = 0, wr_stb = 0, rd_stb = 0, end_stb = 0;
    logic [7:0] dev_byte = 0, wa_byte = 0, wr_byte = 0;
    logic       ack_vld, ack, rd_vld, locked;
    logic [7:0] rd_data;
    logic [2:0] region;
    logic [6:0] byte_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sec_aux_ctrl #(.UID_VALUE(UID)) u0 (
        .clk(clk), .rst(rst), .chip_pins(chip_pins),
        .dev_stb(dev_stb), .dev_byte(dev_byte),
        .wa_stb(wa_stb), .wa_byte(wa_byte),
        .wr_stb(wr_stb), .wr_byte(wr_byte),
        .rd_stb(rd_stb), .end_stb(end_stb),
        .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
        .region(region), .byte_idx(byte_idx), .locked(locked)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // strobe for one cycle, sample half a cycle after the edge that registers it
    task automatic apply(input logic [2:0] op, input logic [7:0] b);
        @(negedge clk);
        dev_stb = (op == OP_DEV); dev_byte = b;
        wa_stb  = (op == OP_WA);  wa_byte  = b;
        wr_stb  = (op == OP_WR);  wr_byte  = b;
        rd_stb  = (op == OP_RD);
        end_stb = (op == OP_END);
        @(negedge clk);
        dev_stb = 0; wa_stb = 0; wr_stb = 0; rd_stb = 0; end_stb = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check(12, "ack_vld after reset", {7'd0, ack_vld}, 8'h00);
        check(12, "rd_vld after reset", {7'd0, rd_vld}, 8'h00);
        check(12, "region after reset", {5'd0, region}, 8'h00);
        check(12, "locked after reset", {7'd0, locked}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [2:0] op;
            logic [7:0] b, e;
            {rq, op, b, e} = VEC[i];
            apply(op, b);
            if (op == OP_RD)
                check(int'(rq), $sformatf("vector %0d read", i), rd_vld ? rd_data : ~e, e);
            else if (op != OP_END)
                check(int'(rq), $sformatf("vector %0d ack", i), ack_vld ? {7'd0, ack} : ~e, e);
        end
        check(6, "lock state after table", {7'd0, locked}, 8'h01);
        apply(OP_END, 8'h00);

        // R9 lock readback when set
        apply(OP_DEV, 8'hBA);
        apply(OP_WA, 8'h04);
        apply(OP_WA, 8'h00);
        apply(OP_DEV, 8'hBB);
        apply(OP_RD, 8'h00);
        check(9, "lock read when locked", rd_vld ? rd_data : 8'hAA, 8'h02);
        apply(OP_END, 8'h00);

        // R4 region code and index
        apply(OP_DEV, 8'hBA);
        apply(OP_WA, 8'h02);
        apply(OP_WA, 8'hFE);
        check(4, "identifier region", {5'd0, region}, 8'h04);
        check(4, "identifier index", {1'b0, byte_idx}, 8'h0E);
        // R2 region code and index, ignored bits set
        apply(OP_WA, 8'hF9);
        apply(OP_WA, 8'h85);
        check(2, "sector region", {5'd0, region}, 8'h02);
        check(2, "sector index", {1'b0, byte_idx}, 8'h05);
        // R3 lock region
        apply(OP_WA, 8'hFC);
        apply(OP_WA, 8'h33);
        check(3, "lock region", {5'd0, region}, 8'h03);

        // R11 closed session ignores strobes
        apply(OP_END, 8'h00);
        check(11, "region after end", {5'd0, region}, 8'h00);
        apply(OP_WR, 8'h77);
        check(11, "write while closed", {7'd0, ack_vld}, 8'h00);
        apply(OP_RD, 8'h00);
        check(11, "read while closed", {7'd0, rd_vld}, 8'h00);
        apply(OP_DEV, 8'hAA);
        check(1, "main region code", {5'd0, region}, 8'h01);
        apply(OP_WR, 8'h77);
        check(11, "write in main session", {7'd0, ack_vld}, 8'h00);
        apply(OP_WA, 8'h00);
        check(11, "address in main session", {7'd0, ack_vld}, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule